// File: doc/BRIEF.md
# Shift/Load Register With JK First-Stage Entry

This block is a small synchronous register (four stages by default, width set by a parameter) with two operating modes. A mode input selects between shifting and loading. When it is high, every rising clock edge moves the contents one stage upward, from bit 0 toward the top bit. The new bit 0 comes from a J/K-bar pair that can set, clear, toggle or keep the old first stage. When the mode input is low, every stage captures its own parallel data input on the edge.

An active-low clear input zeroes the register at once, without waiting for a clock edge. The outputs are every stage plus a complemented copy of the top stage. If J and K-bar are driven from one wire, bit 0 behaves as a plain serial D input. Shift-left behaviour is obtained outside the block by routing each stage n back to data input n-1 while holding the register in load mode.

Top module: `shreg_jk_load`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros and `q_top_n` is 1, and this takes effect without a clock edge, whatever the other inputs are.
- R2: `q_top_n` always equals the inverse of the top stage `q[WIDTH-1]`.
- R3: With `shift_en` = 0, a rising edge copies `par_d` into `q` bit for bit, and `j_in`/`kb_in` have no effect on the result.
- R4: With `shift_en` = 1, a rising edge moves each stage n (n < WIDTH-1) into stage n+1, and `par_d` has no effect on the result.
- R5: In shift mode, `j_in`=1 with `kb_in`=1 makes the new `q[0]` equal to 1.
- R6: In shift mode, `j_in`=0 with `kb_in`=0 makes the new `q[0]` equal to 0.
- R7: In shift mode, `j_in`=1 with `kb_in`=0 makes the new `q[0]` the inverse of the old `q[0]`.
- R8: In shift mode, `j_in`=0 with `kb_in`=1 makes the new `q[0]` equal to the old `q[0]`.
- R9: With `j_in` and `kb_in` driven by the same serial bit, that bit enters `q[0]` on each shift edge.
- R10: After `clr_n` rises, `q` stays zero until the next rising clock edge, and that edge applies the mode selected at that time.
- R11: Holding `shift_en` at 0 with `par_d[n-1]` fed from `q[n]`, and a fill bit on `par_d[WIDTH-1]`, moves the contents one stage toward bit 0 per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward the top bit, 0 = parallel load |
| j_in | input | 1 | J entry for the first stage |
| kb_in | input | 1 | Inverted-K entry for the first stage |
| par_d | input | WIDTH | Parallel data, one bit per stage |
| q | output | WIDTH | Stage contents, bit 0 is the first stage |
| q_top_n | output | 1 | Inverse of the top stage |

## Verification
Every shift or load result becomes visible after the first rising edge that follows the stimulus. The driver sets inputs on a falling edge and queues the value it expects, and the monitor compares that value 2 ns after the next rising edge. The clear is a different case: it is checked 1 ns after `clr_n` falls in the middle of a cycle, before any edge. The released register is then checked again before the first edge after release, so the check proves that nothing moves until that edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // First-stage action, encoded as {j, kb}
    typedef enum logic [1:0] {
        HEAD_CLR  = 2'b00,
        HEAD_KEEP = 2'b01,
        HEAD_FLIP = 2'b10,
        HEAD_SET  = 2'b11
    } head_op_e;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } reg_mode_e;

    function automatic head_op_e decode_head(input logic j, input logic kb);
        return head_op_e'({j, kb});
    endfunction

    function automatic logic apply_head(input head_op_e op, input logic old_bit);
        logic nb;
        case (op)
            HEAD_CLR:  nb = 1'b0;
            HEAD_KEEP: nb = old_bit;
            HEAD_FLIP: nb = ~old_bit;
            default:   nb = 1'b1;
        endcase
        return nb;
    endfunction

endpackage

// File: rtl/shreg_head.sv
module shreg_head
    import shreg_pkg::*;
(
    input  logic j_in,
    input  logic kb_in,
    input  logic cur_bit,
    output logic nxt_bit
);
    head_op_e op;

    always_comb begin
        op      = decode_head(j_in, kb_in);
        nxt_bit = apply_head(op, cur_bit);
    end
endmodule

// File: rtl/shreg_next.sv
module shreg_next
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  reg_mode_e        mode,
    input  logic             head_bit,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] nxt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_shift;
        if (i == 0) begin : g_first
            assign from_shift = head_bit;
        end else begin : g_rest
            assign from_shift = cur[i-1];
        end
        assign nxt[i] = (mode == MODE_SHIFT) ? from_shift : par_d[i];
    end
endmodule

// File: rtl/shreg_store.sv
module shreg_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/shreg_jk_load.sv
module shreg_jk_load
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_en,
    input  logic             j_in,
    input  logic             kb_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] q,
    output logic             q_top_n
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;
    logic             head_bit;
    reg_mode_e        mode;

    assign mode = reg_mode_e'(shift_en);

    shreg_head u_head (
        .j_in    (j_in),
        .kb_in   (kb_in),
        .cur_bit (cur[0]),
        .nxt_bit (head_bit)
    );

    shreg_next #(.WIDTH(WIDTH)) u_next (
        .mode     (mode),
        .head_bit (head_bit),
        .cur      (cur),
        .par_d    (par_d),
        .nxt      (nxt)
    );

    shreg_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    assign q       = cur;
    assign q_top_n = ~cur[TOP];
endmodule

// File: rtl/shreg_jk_load_chk.sv
module shreg_jk_load_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             shift_en,
    input logic             j_in,
    input logic             kb_in,
    input logic [WIDTH-1:0] par_d,
    input logic [WIDTH-1:0] q,
    input logic             q_top_n
);
    p_clear_r1: assert property (@(negedge clk)
        !clr_n |-> (q == '0 && q_top_n == 1'b1));

    p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
        !shift_en |=> q == $past(par_d));

    p_shift_r4: assert property (@(posedge clk) disable iff (!clr_n)
        shift_en |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

    p_set_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && j_in && kb_in) |=> q[0] == 1'b1);

    p_clr_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !j_in && !kb_in) |=> q[0] == 1'b0);

    p_flip_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && j_in && !kb_in) |=> q[0] != $past(q[0]));

    p_keep_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !j_in && kb_in) |=> $stable(q[0]));
endmodule

bind shreg_jk_load shreg_jk_load_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .j_in     (j_in),
    .kb_in    (kb_in),
    .par_d    (par_d),
    .q        (q),
    .q_top_n  (q_top_n)
);

// File: tb/test_shreg_jk_load.sv
module test_shreg_jk_load;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         j_in = 1'b0;
    logic         kb_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_top_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb[$];
    logic [W-1:0] mdl = '0;

    always #4 clk = ~clk;

    shreg_jk_load #(.WIDTH(W)) i_shreg_jk_load (
        .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .j_in(j_in),
        .kb_in(kb_in), .par_d(par_d), .q(q), .q_top_n(q_top_n)
    );

    function automatic logic [W-1:0] ref_next(logic [W-1:0] m, logic se,
                                              logic j, logic kb, logic [W-1:0] d);
        logic h;
        if (!se) return d;
        if (j && kb)        h = 1'b1;
        else if (!j && !kb) h = 1'b0;
        else if (j)         h = ~m[0];
        else                h = m[0];
        return {m[W-2:0], h};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [W:0] act, input logic [W:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual {q_top_n,q}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic se, input logic j, input logic kb,
                        input logic [W-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        shift_en = se; j_in = j; kb_in = kb; par_d = d;
        mdl = ref_next(mdl, se, j, kb, d);
        it.exp = mdl;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: result due 2 ns after the capturing rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(q == it.exp && q_top_n == ~it.exp[W-1], it.tag,
                      {q_top_n, q}, {~it.exp[W-1], it.exp});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(q == '0 && q_top_n, "R1 reset state", {q_top_n, q}, {1'b1, 4'b0000});
        clr_n = 1'b1;
        mdl = '0;

        step(1'b0, 1'b1, 1'b1, 4'b1010, "R3 load, jk ignored");
        step(1'b0, 1'b0, 1'b0, 4'b0101, "R3 load 0101");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R5 R4 shift set");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R6 R4 shift clear");
        step(1'b1, 1'b1, 1'b0, 4'b1111, "R7 toggle");
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R7 toggle again");
        step(1'b1, 1'b0, 1'b1, 4'b0110, "R8 hold");
        step(1'b1, 1'b0, 1'b1, 4'b1001, "R8 hold again");
        step(1'b0, 1'b0, 1'b0, 4'b1000, "R2 top set, inverse low");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R9 tied serial 1");
        step(1'b1, 1'b0, 1'b0, 4'b1111, "R9 tied serial 0");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R9 tied serial 1b");
        step(1'b1, 1'b1, 1'b1, 4'b0000, "R9 tied serial 1c");

        step(1'b0, 1'b0, 1'b0, 4'b1001, "R3 preload for shift-left");
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] fb;
            fb = {1'b0, mdl[W-1:1]};
            step(1'b0, 1'b1, 1'b0, fb, "R11 shift-left feedback");
        end
        step(1'b0, 1'b0, 1'b0, 4'b0110, "R3 load before clear");

        // mid-cycle asynchronous clear
        @(posedge clk);
        #3;
        shift_en = 1'b1; j_in = 1'b1; kb_in = 1'b1;
        clr_n = 1'b0;
        #1;
        check(q == '0 && q_top_n, "R1 async clear mid-cycle", {q_top_n, q}, {1'b1, 4'b0000});
        @(negedge clk);
        clr_n = 1'b1;
        mdl = '0;
        #1;
        check(q == '0 && q_top_n, "R10 zero after release", {q_top_n, q}, {1'b1, 4'b0000});
        begin
            item_t it;
            mdl = ref_next(mdl, 1'b1, 1'b1, 1'b1, par_d);
            it.exp = mdl;
            it.tag = "R10 first edge applies shift";
            sb.push_back(it);
        end
        step(1'b1, 1'b1, 1'b0, 4'b0000, "R7 toggle after release");

        @(posedge clk);
        #3;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                check(1'b0, "watchdog", '0, '0);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule